// File: doc/BRIEF.md
# Two-Level Interrupt Accumulator and Scanner

The block collects interrupt events from a set of peripheral slots. Each slot holds a small per-line status vector, an enable bit and an owner number. A slot is *active* for the selected owner when it is owned by that owner, its enable bit is set and at least one of its status bits is pending. Active slots are packed one bit per slot into 32-bit summary words. The OR of all summary bits drives a single interrupt output.

To service the interrupt, the consumer starts a scan. The scanner walks the summary words from the word that holds the programmed minimum slot up to the word that holds the programmed maximum slot. It finds active slots lowest-first and then each slot's pending lines lowest-first. It reports one (slot, line) pair per hit pulse and ends the scan with a done pulse. The consumer then clears the reported lines with a write-one-to-clear mask. Events, clears, enables and ownership all arrive on simple write ports.

Top module: `irq_accum_scan`

## Requirements
- R1: An event pulse ORs `evt_lines_i` into the status of slot `evt_slot_i`. Status bits stay set until they are cleared.
- R2: A clear pulse clears exactly the bits of slot `clr_slot_i` that are set in `clr_mask_i`. No other bit of that slot or of any other slot changes.
- R3: When a status bit is set and cleared in the same cycle, it ends up set.
- R4: A slot whose enable bit is 0 contributes to no summary bit, to no `irq_o` and to no scan hit, but its status is kept. Enable and owner both reset to 0.
- R5: A slot contributes only when its 3-bit owner equals `owner_sel_i`.
- R6: Bit b of `sum_word_o` is the active flag of slot 32*`sum_idx_i` + b. This is combinational.
- R7: `irq_o` is the OR of all active flags. It is 0 whenever no slot of the selected owner is both enabled and pending.
- R8: The minimum bound resets to 255 and the maximum bound to 0. A scan started with the start word above the end word reports no hits and still pulses `scan_done_o`.
- R9: A scan covers every slot of summary words `min_slot>>5` through `max_slot>>5`, inclusive. No slot outside those words is reported.
- R10: Hits come out in ascending slot order, and within a slot in ascending line order. Each pending (slot, line) pair is reported exactly once, as a one-cycle `hit_valid_o`.
- R11: `scan_done_o` is a one-cycle pulse that follows the last hit. `scan_busy_o` is high from the cycle after the start until the done pulse. A start request is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event strobe |
| evt_slot_i | input | 8 | Slot receiving the event |
| evt_lines_i | input | 8 | Lines to set |
| clr_valid_i | input | 1 | Clear strobe |
| clr_slot_i | input | 8 | Slot to clear |
| clr_mask_i | input | 8 | Write-one-to-clear mask |
| en_we_i | input | 1 | Enable write strobe |
| en_slot_i | input | 8 | Slot whose enable is written |
| en_val_i | input | 1 | New enable value |
| own_we_i | input | 1 | Owner write strobe |
| own_slot_i | input | 8 | Slot whose owner is written |
| own_val_i | input | 3 | New owner |
| owner_sel_i | input | 3 | Owner being serviced |
| bound_we_i | input | 1 | Load both scan bounds |
| min_slot_i | input | 8 | Lowest slot of interest |
| max_slot_i | input | 8 | Highest slot of interest |
| sum_idx_i | input | 3 | Summary word select |
| sum_word_o | output | 32 | Selected summary word |
| irq_o | output | 1 | Summary interrupt |
| scan_start_i | input | 1 | Start a scan |
| scan_busy_o | output | 1 | Scan in progress |
| scan_done_o | output | 1 | Scan finished pulse |
| hit_valid_o | output | 1 | Hit report strobe |
| hit_slot_o | output | 8 | Reported slot |
| hit_line_o | output | 3 | Reported line |

## Verification
Directed patterns act on a single slot with set, partial clear and same-cycle set/clear. These show whether the status update has the right priority and whether clears stay confined to the masked bits. Enable and owner toggles on a pending slot show that gating hides the slot without losing its status. Randomized rounds spread events over many slots, owners and bound pairs, including inverted bounds and bounds inside a word. Comparing every summary word and the full hit sequence against a bench model then separates errors in word coverage, ordering and duplicate or missing hits.

// File: rtl/irq_accum_pkg.sv
package irq_accum_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_PICK,
    S_EMIT,
    S_DONE
  } scan_st_e;
endpackage

// File: rtl/irq_slot_bank.sv
module irq_slot_bank #(
  parameter int NUM_SLOTS = 256,
  parameter int LINES     = 8,
  parameter int OWN_W     = 3,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       evt_valid_i,
  input  logic [SLOT_W-1:0]          evt_slot_i,
  input  logic [LINES-1:0]           evt_lines_i,
  input  logic                       clr_valid_i,
  input  logic [SLOT_W-1:0]          clr_slot_i,
  input  logic [LINES-1:0]           clr_mask_i,
  input  logic                       en_we_i,
  input  logic [SLOT_W-1:0]          en_slot_i,
  input  logic                       en_val_i,
  input  logic                       own_we_i,
  input  logic [SLOT_W-1:0]          own_slot_i,
  input  logic [OWN_W-1:0]           own_val_i,
  input  logic [OWN_W-1:0]           owner_sel_i,
  output logic [NUM_SLOTS*LINES-1:0] status_o,
  output logic [NUM_SLOTS-1:0]       active_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [LINES-1:0] st_q;
    logic             en_q;
    logic [OWN_W-1:0] own_q;
    logic [LINES-1:0] set_m, clr_m;

    assign set_m = (evt_valid_i && evt_slot_i == SLOT_W'(g)) ? evt_lines_i : '0;
    assign clr_m = (clr_valid_i && clr_slot_i == SLOT_W'(g)) ? clr_mask_i : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= '0;
        en_q  <= 1'b0;
        own_q <= '0;
      end else begin
        st_q <= (st_q & ~clr_m) | set_m;  // set wins over clear
        if (en_we_i && en_slot_i == SLOT_W'(g)) en_q <= en_val_i;
        if (own_we_i && own_slot_i == SLOT_W'(g)) own_q <= own_val_i;
      end
    end

    assign status_o[g*LINES +: LINES] = st_q;
    assign active_o[g] = en_q && (own_q == owner_sel_i) && (|st_q);
  end
endmodule

// File: rtl/irq_scanner.sv
module irq_scanner
  import irq_accum_pkg::*;
#(
  parameter int NUM_SLOTS = 256,
  parameter int LINES     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int LINE_W   = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int WIDX_W   = SLOT_W - 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SLOTS-1:0]       active_i,
  input  logic [NUM_SLOTS*LINES-1:0] status_i,
  input  logic [SLOT_W-1:0]          min_slot_i,
  input  logic [SLOT_W-1:0]          max_slot_i,
  input  logic                       start_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       hit_valid_o,
  output logic [SLOT_W-1:0]          hit_slot_o,
  output logic [LINE_W-1:0]          hit_line_o
);
  localparam int IDX_W = SLOT_W + LINE_W + 1;

  scan_st_e          st_q;
  logic [WIDX_W-1:0] widx_q, last_q;
  logic [31:0]       word_pend_q;
  logic [LINES-1:0]  line_pend_q;
  logic [SLOT_W-1:0] cur_slot_q;

  logic [4:0]        low_bit;
  logic [LINE_W-1:0] low_line;
  logic [SLOT_W-1:0] pick_slot;
  logic [IDX_W-1:0]  line_base;
  logic [WIDX_W-1:0] first_w, last_w;

  always_comb begin
    low_bit = '0;
    for (int i = 31; i >= 0; i--) if (word_pend_q[i]) low_bit = 5'(i);
    low_line = '0;
    for (int i = LINES-1; i >= 0; i--) if (line_pend_q[i]) low_line = LINE_W'(i);
  end

  assign pick_slot = {widx_q, low_bit};
  assign line_base = IDX_W'(pick_slot) * IDX_W'(LINES);
  assign first_w   = min_slot_i[SLOT_W-1:5];
  assign last_w    = max_slot_i[SLOT_W-1:5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      widx_q      <= '0;
      last_q      <= '0;
      word_pend_q <= '0;
      line_pend_q <= '0;
      cur_slot_q  <= '0;
      done_o      <= 1'b0;
      hit_valid_o <= 1'b0;
      hit_slot_o  <= '0;
      hit_line_o  <= '0;
    end else begin
      done_o      <= 1'b0;
      hit_valid_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          widx_q <= first_w;
          last_q <= last_w;
          st_q   <= (first_w > last_w) ? S_DONE : S_LOAD;
        end
        S_LOAD: begin
          word_pend_q <= active_i[{widx_q, 5'd0} +: 32];
          st_q        <= S_PICK;
        end
        S_PICK: begin
          if (word_pend_q == '0) begin
            if (widx_q == last_q) st_q <= S_DONE;
            else begin
              widx_q <= widx_q + 1'b1;
              st_q   <= S_LOAD;
            end
          end else begin
            cur_slot_q           <= pick_slot;
            word_pend_q[low_bit] <= 1'b0;
            line_pend_q          <= status_i[line_base +: LINES];
            st_q                 <= S_EMIT;
          end
        end
        S_EMIT: begin
          if (line_pend_q == '0) st_q <= S_PICK;
          else begin
            hit_valid_o           <= 1'b1;
            hit_slot_o            <= cur_slot_q;
            hit_line_o            <= low_line;
            line_pend_q[low_line] <= 1'b0;
          end
        end
        S_DONE: begin
          done_o <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
endmodule

// File: rtl/irq_accum_scan.sv
module irq_accum_scan #(
  parameter int NUM_SLOTS = 256,
  parameter int LINES     = 8,
  parameter int OWN_W     = 3,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int LINE_W   = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int WIDX_W   = SLOT_W - 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [SLOT_W-1:0] evt_slot_i,
  input  logic [LINES-1:0]  evt_lines_i,
  input  logic              clr_valid_i,
  input  logic [SLOT_W-1:0] clr_slot_i,
  input  logic [LINES-1:0]  clr_mask_i,
  input  logic              en_we_i,
  input  logic [SLOT_W-1:0] en_slot_i,
  input  logic              en_val_i,
  input  logic              own_we_i,
  input  logic [SLOT_W-1:0] own_slot_i,
  input  logic [OWN_W-1:0]  own_val_i,
  input  logic [OWN_W-1:0]  owner_sel_i,
  input  logic              bound_we_i,
  input  logic [SLOT_W-1:0] min_slot_i,
  input  logic [SLOT_W-1:0] max_slot_i,
  input  logic [WIDX_W-1:0] sum_idx_i,
  output logic [31:0]       sum_word_o,
  output logic              irq_o,
  input  logic              scan_start_i,
  output logic              scan_busy_o,
  output logic              scan_done_o,
  output logic              hit_valid_o,
  output logic [SLOT_W-1:0] hit_slot_o,
  output logic [LINE_W-1:0] hit_line_o
);
  logic [NUM_SLOTS*LINES-1:0] status_flat;
  logic [NUM_SLOTS-1:0]       active;
  logic [SLOT_W-1:0]          min_q, max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= SLOT_W'(NUM_SLOTS-1);
      max_q <= '0;
    end else if (bound_we_i) begin
      min_q <= min_slot_i;
      max_q <= max_slot_i;
    end
  end

  irq_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .LINES(LINES), .OWN_W(OWN_W)) u_bank (
    .clk_i, .rst_ni,
    .evt_valid_i, .evt_slot_i, .evt_lines_i,
    .clr_valid_i, .clr_slot_i, .clr_mask_i,
    .en_we_i, .en_slot_i, .en_val_i,
    .own_we_i, .own_slot_i, .own_val_i,
    .owner_sel_i,
    .status_o (status_flat),
    .active_o (active)
  );

  irq_scanner #(.NUM_SLOTS(NUM_SLOTS), .LINES(LINES)) u_scan (
    .clk_i, .rst_ni,
    .active_i    (active),
    .status_i    (status_flat),
    .min_slot_i  (min_q),
    .max_slot_i  (max_q),
    .start_i     (scan_start_i),
    .busy_o      (scan_busy_o),
    .done_o      (scan_done_o),
    .hit_valid_o,
    .hit_slot_o,
    .hit_line_o
  );

  assign sum_word_o = active[{sum_idx_i, 5'd0} +: 32];
  assign irq_o      = |active;
endmodule

// File: rtl/irq_accum_chk.sv
module irq_accum_chk #(
  parameter int NUM_SLOTS = 256,
  parameter int LINES     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int LINE_W   = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int WIDX_W   = SLOT_W - 5
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       evt_valid_i,
  input logic [SLOT_W-1:0]          evt_slot_i,
  input logic [LINES-1:0]           evt_lines_i,
  input logic                       clr_valid_i,
  input logic [SLOT_W-1:0]          clr_slot_i,
  input logic [NUM_SLOTS*LINES-1:0] status_flat,
  input logic [SLOT_W-1:0]          min_q,
  input logic [SLOT_W-1:0]          max_q,
  input logic                       irq_o,
  input logic                       scan_start_i,
  input logic                       scan_busy_o,
  input logic                       scan_done_o,
  input logic                       hit_valid_o,
  input logic [SLOT_W-1:0]          hit_slot_o,
  input logic [LINE_W-1:0]          hit_line_o
);
  logic              sw_vld_q;
  logic [SLOT_W-1:0] sw_slot_q;
  logic [LINES-1:0]  sw_lines_q;
  logic [WIDX_W-1:0] c_first_q, c_last_q;
  logic              have_prev_q;
  logic [SLOT_W+LINE_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_vld_q    <= 1'b0;
      sw_slot_q   <= '0;
      sw_lines_q  <= '0;
      c_first_q   <= '0;
      c_last_q    <= '0;
      have_prev_q <= 1'b0;
      prev_q      <= '0;
    end else begin
      sw_vld_q   <= evt_valid_i && clr_valid_i && (evt_slot_i == clr_slot_i);
      sw_slot_q  <= evt_slot_i;
      sw_lines_q <= evt_lines_i;
      if (scan_start_i && !scan_busy_o) begin
        c_first_q   <= min_q[SLOT_W-1:5];
        c_last_q    <= max_q[SLOT_W-1:5];
        have_prev_q <= 1'b0;
      end else if (hit_valid_o) begin
        have_prev_q <= 1'b1;
        prev_q      <= {hit_slot_o, hit_line_o};
      end
    end
  end

  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_vld_q |-> ((status_flat[sw_slot_q*LINES +: LINES] & sw_lines_q) == sw_lines_q));

  p_irq_needs_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|status_flat));

  p_hit_in_words_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> (hit_slot_o[SLOT_W-1:5] >= c_first_q && hit_slot_o[SLOT_W-1:5] <= c_last_q));

  p_ascending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_o && have_prev_q) |-> ({hit_slot_o, hit_line_o} > prev_q));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> !scan_done_o);

  p_hit_while_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> scan_busy_o);
endmodule

bind irq_accum_scan irq_accum_chk #(.NUM_SLOTS(NUM_SLOTS), .LINES(LINES)) u_chk (
  .clk_i, .rst_ni, .evt_valid_i, .evt_slot_i, .evt_lines_i,
  .clr_valid_i, .clr_slot_i, .status_flat, .min_q, .max_q, .irq_o,
  .scan_start_i, .scan_busy_o, .scan_done_o, .hit_valid_o, .hit_slot_o, .hit_line_o
);

// File: tb/tb_irq_accum_scan.sv
module tb_irq_accum_scan;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic evt_valid_i = 0, clr_valid_i = 0, en_we_i = 0, en_val_i = 0, own_we_i = 0;
  logic bound_we_i = 0, scan_start_i = 0;
  logic [7:0] evt_slot_i = 0, evt_lines_i = 0, clr_slot_i = 0, clr_mask_i = 0;
  logic [7:0] en_slot_i = 0, own_slot_i = 0, min_slot_i = 0, max_slot_i = 0;
  logic [2:0] own_val_i = 0, owner_sel_i = 0, sum_idx_i = 0;
  logic [31:0] sum_word_o;
  logic irq_o, scan_busy_o, scan_done_o, hit_valid_o;
  logic [7:0] hit_slot_o;
  logic [2:0] hit_line_o;

  always #4 clk_i = ~clk_i;

  irq_accum_scan dut (.*);

  int n_chk = 0, n_fail = 0;
  bit [7:0] m_st[256];
  bit       m_en[256];
  bit [2:0] m_own[256];
  int       m_min = 255, m_max = 0;
  int       exp_s[2048], exp_l[2048], got_s[2048], got_l[2048];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  function automatic bit act(int s);
    return m_en[s] && (m_own[s] == owner_sel_i) && (m_st[s] != 0);
  endfunction

  function automatic logic [31:0] exp_word(int idx);
    logic [31:0] w = '0;
    for (int b = 0; b < 32; b++) w[b] = act(idx*32 + b);
    return w;
  endfunction

  function automatic bit exp_irq();
    for (int s = 0; s < 256; s++) if (act(s)) return 1;
    return 0;
  endfunction

  task automatic evt_clr(bit ev, int s, int lines, bit cv, int cs, int mask);
    @(negedge clk_i);
    evt_valid_i = ev; evt_slot_i = 8'(s); evt_lines_i = 8'(lines);
    clr_valid_i = cv; clr_slot_i = 8'(cs); clr_mask_i = 8'(mask);
    @(negedge clk_i);
    evt_valid_i = 0; clr_valid_i = 0;
    if (cv) m_st[cs] &= ~8'(mask);
    if (ev) m_st[s] |= 8'(lines);
  endtask

  task automatic set_cfg(int s, bit en, int own);
    @(negedge clk_i);
    en_we_i = 1; en_slot_i = 8'(s); en_val_i = en;
    own_we_i = 1; own_slot_i = 8'(s); own_val_i = 3'(own);
    @(negedge clk_i);
    en_we_i = 0; own_we_i = 0;
    m_en[s] = en; m_own[s] = 3'(own);
  endtask

  task automatic set_bounds(int lo, int hi);
    @(negedge clk_i);
    bound_we_i = 1; min_slot_i = 8'(lo); max_slot_i = 8'(hi);
    @(negedge clk_i);
    bound_we_i = 0; m_min = lo; m_max = hi;
  endtask

  task automatic check_words(string req);
    bit ok = 1;
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      sum_idx_i = 3'(i);
      #1;
      if (sum_word_o !== exp_word(i)) begin ok = 0; bad = i; end
    end
    sum_idx_i = 3'(bad); #1;
    chk(ok, {req, " summary word"}, int'(sum_word_o), int'(exp_word(bad)));
    chk(irq_o === exp_irq(), {req, " irq_o"}, int'(irq_o), int'(exp_irq()));
  endtask

  task automatic run_scan(string req);
    int ne = 0, ng = 0, guard = 0, fw, lw;
    bit ok = 1, done = 0;
    fw = m_min >> 5; lw = m_max >> 5;
    if (fw <= lw)
      for (int s = fw*32; s < lw*32 + 32; s++)
        if (act(s))
          for (int l = 0; l < 8; l++)
            if (m_st[s][l]) begin exp_s[ne] = s; exp_l[ne] = l; ne++; end
    @(negedge clk_i);
    scan_start_i = 1;
    @(negedge clk_i);
    scan_start_i = 0;
    chk(scan_busy_o === 1'b1, {req, " busy after start (R11)"}, int'(scan_busy_o), 1);
    while (!done && guard < 5000) begin
      @(negedge clk_i);
      guard++;
      if (hit_valid_o === 1'b1 && ng < 2048) begin
        got_s[ng] = hit_slot_o; got_l[ng] = hit_line_o; ng++;
      end
      if (scan_done_o === 1'b1) done = 1;
    end
    chk(done, {req, " done pulse (R11)"}, int'(done), 1);
    chk(ng == ne, {req, " hit count (R9)"}, ng, ne);
    for (int i = 0; i < ng && i < ne; i++)
      if (got_s[i] != exp_s[i] || got_l[i] != exp_l[i]) begin
        if (ok) chk(0, {req, " hit order (R10)"}, got_s[i]*8 + got_l[i], exp_s[i]*8 + exp_l[i]);
        ok = 0;
      end
    if (ok) chk(1, {req, " hit order (R10)"}, 0, 0);
    @(negedge clk_i);
    chk(scan_busy_o === 1'b0 && scan_done_o === 1'b0, {req, " idle after done (R11)"},
        int'({scan_busy_o, scan_done_o}), 0);
  endtask

  initial begin
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state
    chk(irq_o === 1'b0, "R7 reset irq", int'(irq_o), 0);
    chk(scan_busy_o === 1'b0 && hit_valid_o === 1'b0, "R11 reset idle",
        int'({scan_busy_o, hit_valid_o}), 0);
    check_words("R4 reset");

    // R8: bounds at reset values, pending slot present
    set_cfg(5, 1, 0);
    evt_clr(1, 5, 8'h04, 0, 0, 0);
    check_words("R1 first event");
    run_scan("R8 reset bounds");

    // R1 / R2 / R3 on a single slot
    set_bounds(0, 31);
    evt_clr(1, 5, 8'h03, 0, 0, 0);
    run_scan("R1 accumulate");
    evt_clr(0, 0, 0, 1, 5, 8'h02);
    run_scan("R2 partial clear");
    evt_clr(1, 5, 8'h01, 1, 5, 8'h01);
    run_scan("R3 set and clear same cycle");
    evt_clr(1, 5, 8'h80, 1, 5, 8'h05);
    run_scan("R3 set other bits while clearing");

    // R4 enable gating keeps status
    set_cfg(5, 0, 0);
    check_words("R4 disabled");
    run_scan("R4 disabled scan");
    set_cfg(5, 1, 0);
    check_words("R4 re-enabled");
    run_scan("R4 re-enabled scan");

    // R5 ownership
    set_cfg(5, 1, 2);
    check_words("R5 other owner");
    owner_sel_i = 3'd2;
    check_words("R5 owner selected");
    run_scan("R5 owner scan");
    owner_sel_i = 3'd0;

    // R9 bounds covering whole words, upper words
    set_cfg(40, 1, 0); set_cfg(63, 1, 0); set_cfg(64, 1, 0); set_cfg(255, 1, 0);
    evt_clr(1, 40, 8'h11, 0, 0, 0);
    evt_clr(1, 63, 8'h80, 0, 0, 0);
    evt_clr(1, 64, 8'h01, 0, 0, 0);
    evt_clr(1, 255, 8'hff, 0, 0, 0);
    set_bounds(50, 60);
    run_scan("R9 single word");
    set_bounds(33, 255);
    run_scan("R9 to last word");

    // randomized rounds
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 50; k++)
        set_cfg($urandom_range(0, 255), $urandom_range(0, 3) != 0, $urandom_range(0, 3));
      for (int k = 0; k < 60; k++)
        evt_clr(1, $urandom_range(0, 255), $urandom_range(1, 255),
                $urandom_range(0, 3) == 0, $urandom_range(0, 255), $urandom_range(0, 255));
      owner_sel_i = 3'($urandom_range(0, 3));
      check_words("R6 random");
      set_bounds($urandom_range(0, 255), $urandom_range(0, 255));
      run_scan("R10 random");
    end

    // R7: irq stays until the last pending bit of the selected owner is cleared
    owner_sel_i = 3'd0;
    set_cfg(200, 1, 0);
    evt_clr(1, 200, 8'h08, 0, 0, 0);
    for (int s = 0; s < 256; s++)
      if (s != 200 && m_st[s] != 0) evt_clr(0, 0, 0, 1, s, 8'hff);
    check_words("R7 one pending left");
    chk(irq_o === 1'b1, "R7 irq held", int'(irq_o), 1);
    evt_clr(0, 0, 0, 1, 200, 8'hf7);
    chk(irq_o === 1'b1, "R2 unmasked bit kept, irq held (R7)", int'(irq_o), 1);
    evt_clr(0, 0, 0, 1, 200, 8'h08);
    chk(irq_o === 1'b0, "R7 irq drops", int'(irq_o), 0);
    check_words("R7 all clear");
    set_bounds(0, 255);
    run_scan("R9 empty full range");

    finish_run();
  end
endmodule